// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block gathers the interrupt-worthy events of a seven-channel display fetch engine into two sticky status words. It combines them with mask bits held in two control words and drives a single level-sensitive interrupt line. Channel 0 is the base plane. Its events, and the global events (underruns, quick disable, last frame done, read status, command done), sit in the first status word. The start-of-frame, end-of-frame, branch and underrun events of channels 1 to 6 sit in the second.

Each channel also presents the frame ID of its current descriptor. The first unmasked frame event that arrives while the interrupt line is low copies that ID into an ID register, so software can see which frame raised the interrupt. An event that arrives while the line is already high leaves the ID alone and sets a "subsequent interrupt" flag instead. A bus error skips the masks, records the failing channel number, and follows the same ID-or-flag rule. Software reads the registers and clears status bits by writing ones through a simple synchronous register port.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset, both status words, both control words, the ID register and `irq_o` are all zero.
- R2: Status word 0 records these events: last frame done at bit 0, channel-0 SOF at bit 1, bus error at bit 2, channel-0 underrun at bit 4, channel-1 underrun at bit 5, output underrun at bit 6, quick disable at bit 7, channel-0 EOF at bit 8, channel-0 branch at bit 9, subsequent interrupt at bit 10, read status at bit 11 and command done at bit 12. Each bit is set in the clock edge after its event pulse.
- R3: For channel c from 1 to 6, status word 1 records SOF at bit c-1, EOF at bit c+7 and branch at bit c+15. For c from 2 to 6 it records underrun at bit c+23.
- R4: A SOF or EOF pulse is recorded only when that channel's command-word SOF-enable or EOF-enable input is high. Otherwise it changes no status bit, no ID and no interrupt.
- R5: `irq_o` is a register. It rises one edge after a status bit is set whose mask is clear, and it stays low while every set bit is masked. Status-0 bits 0, 1, 4, 6, 7, 8, 9, 11 and 12 are masked by control-0 bits 3, 4, 5, 21, 11, 6, 20, 23 and 24. Status-0 bit 5 is masked by control-5 bit 24. Each status-1 bit is masked by the control-5 bit at the same position. Bus error and subsequent interrupt never drive the line.
- R6: When `irq_o` is low, an unmasked SOF, EOF or branch event, or a bus error, loads that channel's frame ID into the ID register. If several channels qualify in one cycle, the highest-numbered one wins. Masked events load nothing.
- R7: When `irq_o` is high, such an event sets status-0 bit 10 and leaves the ID register unchanged.
- R8: A bus error on channel n sets status-0 bit 2 and writes n into status-0 bits 30:28, whatever the masks say.
- R9: A write to status word 0 clears every bit among 11:0 that is written as one. Bit 12 cannot be cleared this way. Writing a one to bit 2 also clears bits 30:28.
- R10: A write to status word 1 clears only the bits that are written as one inside 0x003E3F3F. Bit 16 and bits 29:24 stay set.
- R11: If an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R12: A control-0 write that changes bit 0 from 1 to 0 sets status-0 bit 7.
- R13: The register port uses addresses 0 for control 0, 1 for control 5, 2 for status 0, 3 for status 1 and 4 for the ID register. Control 0 keeps bits 26:0 and control 5 keeps the bits in 0x3F3F3F3F.
- R14: A read-status event sets status-0 bit 11. It also sets bit 10, but only when `irq_o` is high and control-0 bit 23 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ev_sof | input | NCH | Start-of-frame pulses, one per channel |
| ev_eof | input | NCH | End-of-frame pulses |
| ev_bs | input | NCH | Branch-taken pulses |
| cmd_sof_en | input | NCH | SOF-interrupt enable from each channel's command word |
| cmd_eof_en | input | NCH | EOF-interrupt enable from each channel's command word |
| ev_ber | input | 1 | Bus error pulse |
| ev_ber_ch | input | CH_W | Channel of the bus error |
| ev_underrun | input | NCH | Input underrun pulses |
| ev_out_underrun | input | 1 | Output underrun pulse |
| ev_last_done | input | 1 | Last frame done pulse |
| ev_read_status | input | 1 | Panel read status pulse |
| ev_cmd_done | input | 1 | Command interrupt pulse |
| frame_id_flat | input | NCH*FID_W | Current frame ID of each channel, channel 0 in the low bits |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is one where the interrupt line is already high when a second qualifying event arrives. Only then does the ID register have to hold while the subsequent-interrupt flag sets. Because the line is registered, the stimulus first sends an unmasked start of frame and waits one edge so the line is high. Only after that does it send the second event, or the read-status event under both mask settings. Two other corners need stimulus that lands in the same cycle: the clear-versus-set collision, and events on several channels at once for the ID priority.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

  localparam int RW = 32;

  typedef enum logic [2:0] {
    RA_CTRL0 = 3'd0,
    RA_CTRL5 = 3'd1,
    RA_STAT0 = 3'd2,
    RA_STAT1 = 3'd3,
    RA_IRQID = 3'd4
  } reg_sel_e;

  // status word 0 bit positions
  localparam int S0_LDD  = 0;
  localparam int S0_SOF  = 1;
  localparam int S0_BER  = 2;
  localparam int S0_IU0  = 4;
  localparam int S0_IU1  = 5;
  localparam int S0_OU   = 6;
  localparam int S0_QD   = 7;
  localparam int S0_EOF  = 8;
  localparam int S0_BS   = 9;
  localparam int S0_SINT = 10;
  localparam int S0_RDST = 11;
  localparam int S0_CMD  = 12;
  localparam int S0_BCH  = 28;

  // control word 0 bit positions
  localparam int C0_EN     = 0;
  localparam int C0_M_LDD  = 3;
  localparam int C0_M_SOF  = 4;
  localparam int C0_M_IU0  = 5;
  localparam int C0_M_EOF  = 6;
  localparam int C0_M_QD   = 11;
  localparam int C0_M_BS   = 20;
  localparam int C0_M_OU   = 21;
  localparam int C0_M_RDST = 23;
  localparam int C0_M_CMD  = 24;

  localparam logic [RW-1:0] C0_KEEP = 32'h07FF_FFFF;
  localparam logic [RW-1:0] C5_KEEP = 32'h3F3F_3F3F;
  localparam logic [RW-1:0] S1_CLR  = 32'h003E_3F3F;

  // status word 1 / control word 5 positions for channel c
  function automatic int s1_sof(int c); return c - 1;  endfunction
  function automatic int s1_eof(int c); return c + 7;  endfunction
  function automatic int s1_bs (int c); return c + 15; endfunction
  function automatic int s1_iu (int c); return c + 23; endfunction

  // bits of status word 0 that currently drive the interrupt line
  function automatic logic [RW-1:0] s0_live(logic [RW-1:0] c0, logic [RW-1:0] c5);
    logic [RW-1:0] v;
    v = '0;
    v[S0_LDD]  = ~c0[C0_M_LDD];
    v[S0_SOF]  = ~c0[C0_M_SOF];
    v[S0_IU0]  = ~c0[C0_M_IU0];
    v[S0_IU1]  = ~c5[s1_iu(1)];
    v[S0_OU]   = ~c0[C0_M_OU];
    v[S0_QD]   = ~c0[C0_M_QD];
    v[S0_EOF]  = ~c0[C0_M_EOF];
    v[S0_BS]   = ~c0[C0_M_BS];
    v[S0_RDST] = ~c0[C0_M_RDST];
    v[S0_CMD]  = ~c0[C0_M_CMD];
    return v;
  endfunction

  function automatic logic irq_level(logic [RW-1:0] s0, logic [RW-1:0] s1,
                                     logic [RW-1:0] c0, logic [RW-1:0] c5);
    return (|(s0 & s0_live(c0, c5))) | (|(s1 & ~c5));
  endfunction

endpackage

// File: rtl/disp_irq_ctl_regs.sv
module disp_irq_ctl_regs
  import disp_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_c0,
  input  logic          wr_c5,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] ctl0,
  output logic [RW-1:0] ctl5,
  output logic          qd_evt
);

  // enable falling through a control-0 write
  assign qd_evt = wr_c0 & ctl0[C0_EN] & ~wdata[C0_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0;
      ctl5 <= '0;
    end else begin
      if (wr_c0) ctl0 <= wdata & C0_KEEP;
      if (wr_c5) ctl5 <= wdata & C5_KEEP;
    end
  end

endmodule

// File: rtl/disp_irq_event_map.sv
module disp_irq_event_map
  import disp_irq_pkg::*;
#(
  parameter int NCH  = 7,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic [RW-1:0]   ctl0,
  input  logic [RW-1:0]   ctl5,
  input  logic [NCH-1:0]  ev_sof,
  input  logic [NCH-1:0]  ev_eof,
  input  logic [NCH-1:0]  ev_bs,
  input  logic [NCH-1:0]  cmd_sof_en,
  input  logic [NCH-1:0]  cmd_eof_en,
  input  logic            ev_ber,
  input  logic [CH_W-1:0] ev_ber_ch,
  input  logic [NCH-1:0]  ev_underrun,
  input  logic            ev_out_underrun,
  input  logic            ev_last_done,
  input  logic            ev_read_status,
  input  logic            ev_cmd_done,
  output logic [RW-1:0]   set0,
  output logic [RW-1:0]   set1,
  output logic [NCH-1:0]  hit,
  output logic            rdst_live
);

  logic [NCH-1:0] sof_ok, eof_ok;
  assign sof_ok    = ev_sof & cmd_sof_en;
  assign eof_ok    = ev_eof & cmd_eof_en;
  assign rdst_live = ev_read_status & ~ctl0[C0_M_RDST];

  always_comb begin
    set0 = '0;
    set0[S0_LDD]  = ev_last_done;
    set0[S0_SOF]  = sof_ok[0];
    set0[S0_BER]  = ev_ber;
    set0[S0_IU0]  = ev_underrun[0];
    set0[S0_IU1]  = ev_underrun[1];
    set0[S0_OU]   = ev_out_underrun;
    set0[S0_EOF]  = eof_ok[0];
    set0[S0_BS]   = ev_bs[0];
    set0[S0_RDST] = ev_read_status;
    set0[S0_CMD]  = ev_cmd_done;
  end

  always_comb begin
    set1 = '0;
    for (int c = 1; c < NCH; c++) begin
      set1[s1_sof(c)] = sof_ok[c];
      set1[s1_eof(c)] = eof_ok[c];
      set1[s1_bs(c)]  = ev_bs[c];
      if (c >= 2) set1[s1_iu(c)] = ev_underrun[c];
    end
  end

  // per-channel qualifying event: unmasked frame event or bus error
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic m_sof, m_eof, m_bs;
    if (c == 0) begin : g_base
      assign m_sof = ctl0[C0_M_SOF];
      assign m_eof = ctl0[C0_M_EOF];
      assign m_bs  = ctl0[C0_M_BS];
    end else begin : g_ovl
      assign m_sof = ctl5[s1_sof(c)];
      assign m_eof = ctl5[s1_eof(c)];
      assign m_bs  = ctl5[s1_bs(c)];
    end
    assign hit[c] = (sof_ok[c] & ~m_sof) | (eof_ok[c] & ~m_eof) |
                    (ev_bs[c] & ~m_bs) | (ev_ber && (ev_ber_ch == CH_W'(c)));
  end

endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
#(
  parameter int NCH   = 7,
  parameter int FID_W = 32,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_s0,
  input  logic               wr_s1,
  input  logic [RW-1:0]      wdata,
  input  logic [RW-1:0]      set0,
  input  logic [RW-1:0]      set1,
  input  logic [NCH-1:0]     hit,
  input  logic               rdst_live,
  input  logic               qd_evt,
  input  logic               ev_ber,
  input  logic [CH_W-1:0]    ev_ber_ch,
  input  logic [NCH*FID_W-1:0] frame_id_flat,
  input  logic [RW-1:0]      ctl0,
  input  logic [RW-1:0]      ctl5,
  output logic [RW-1:0]      stat0,
  output logic [RW-1:0]      stat1,
  output logic [FID_W-1:0]   irq_id,
  output logic               irq_o,
  output logic               sint_evt,
  output logic               id_load
);

  logic [CH_W-1:0]  sel;
  logic [FID_W-1:0] fid_sel;
  logic             any_hit;
  logic [RW-1:0]    clr0, clr1, full_set0, s0_n, s1_n;

  // highest-numbered qualifying channel supplies the ID
  always_comb begin
    sel = '0;
    for (int c = 0; c < NCH; c++) if (hit[c]) sel = CH_W'(c);
  end
  assign fid_sel = frame_id_flat[sel*FID_W +: FID_W];

  assign any_hit  = |hit;
  assign sint_evt = irq_o & (any_hit | rdst_live);
  assign id_load  = ~irq_o & any_hit;

  always_comb begin
    clr0 = '0;
    if (wr_s0) begin
      clr0[11:0] = wdata[11:0];
      if (wdata[S0_BER]) clr0[S0_BCH +: 3] = 3'b111;
    end
    clr1 = wr_s1 ? (wdata & S1_CLR) : '0;
    full_set0 = set0;
    full_set0[S0_QD]   = set0[S0_QD] | qd_evt;
    full_set0[S0_SINT] = set0[S0_SINT] | sint_evt;
    s0_n = (stat0 & ~clr0) | full_set0;
    if (ev_ber) s0_n[S0_BCH +: 3] = 3'(ev_ber_ch);
    s1_n = (stat1 & ~clr1) | set1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat0  <= '0;
      stat1  <= '0;
      irq_id <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat0 <= s0_n;
      stat1 <= s1_n;
      if (id_load) irq_id <= fid_sel;
      irq_o <= irq_level(stat0, stat1, ctl0, ctl5);
    end
  end

endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
#(
  parameter int NCH   = 7,
  parameter int FID_W = 32,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NCH-1:0]       ev_sof,
  input  logic [NCH-1:0]       ev_eof,
  input  logic [NCH-1:0]       ev_bs,
  input  logic [NCH-1:0]       cmd_sof_en,
  input  logic [NCH-1:0]       cmd_eof_en,
  input  logic                 ev_ber,
  input  logic [CH_W-1:0]      ev_ber_ch,
  input  logic [NCH-1:0]       ev_underrun,
  input  logic                 ev_out_underrun,
  input  logic                 ev_last_done,
  input  logic                 ev_read_status,
  input  logic                 ev_cmd_done,
  input  logic [NCH*FID_W-1:0] frame_id_flat,
  output logic                 irq_o
);

  logic [RW-1:0]    ctl0, ctl5, stat0, stat1, set0, set1;
  logic [FID_W-1:0] irq_id;
  logic [NCH-1:0]   hit;
  logic             rdst_live, qd_evt, sint_evt, id_load;
  logic             wr_c0, wr_c5, wr_s0, wr_s1;

  assign wr_c0 = reg_wr && (reg_addr == RA_CTRL0);
  assign wr_c5 = reg_wr && (reg_addr == RA_CTRL5);
  assign wr_s0 = reg_wr && (reg_addr == RA_STAT0);
  assign wr_s1 = reg_wr && (reg_addr == RA_STAT1);

  disp_irq_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_c0(wr_c0), .wr_c5(wr_c5),
    .wdata(reg_wdata), .ctl0(ctl0), .ctl5(ctl5), .qd_evt(qd_evt)
  );

  disp_irq_event_map #(.NCH(NCH)) u_map (
    .ctl0(ctl0), .ctl5(ctl5), .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_bs(ev_bs),
    .cmd_sof_en(cmd_sof_en), .cmd_eof_en(cmd_eof_en), .ev_ber(ev_ber),
    .ev_ber_ch(ev_ber_ch), .ev_underrun(ev_underrun),
    .ev_out_underrun(ev_out_underrun), .ev_last_done(ev_last_done),
    .ev_read_status(ev_read_status), .ev_cmd_done(ev_cmd_done),
    .set0(set0), .set1(set1), .hit(hit), .rdst_live(rdst_live)
  );

  disp_irq_status #(.NCH(NCH), .FID_W(FID_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_s0(wr_s0), .wr_s1(wr_s1), .wdata(reg_wdata),
    .set0(set0), .set1(set1), .hit(hit), .rdst_live(rdst_live), .qd_evt(qd_evt),
    .ev_ber(ev_ber), .ev_ber_ch(ev_ber_ch), .frame_id_flat(frame_id_flat),
    .ctl0(ctl0), .ctl5(ctl5), .stat0(stat0), .stat1(stat1), .irq_id(irq_id),
    .irq_o(irq_o), .sint_evt(sint_evt), .id_load(id_load)
  );

  always_comb begin
    case (reg_addr)
      RA_CTRL0: reg_rdata = ctl0;
      RA_CTRL5: reg_rdata = ctl5;
      RA_STAT0: reg_rdata = stat0;
      RA_STAT1: reg_rdata = stat1;
      RA_IRQID: reg_rdata = RW'(irq_id);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/disp_irq_chk.sv
module disp_irq_chk
  import disp_irq_pkg::*;
#(
  parameter int NCH   = 7,
  parameter int FID_W = 32,
  localparam int CH_W = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [RW-1:0]    stat0,
  input logic [RW-1:0]    stat1,
  input logic [RW-1:0]    ctl0,
  input logic [RW-1:0]    ctl5,
  input logic [FID_W-1:0] irq_id,
  input logic [NCH-1:0]   hit,
  input logic             qd_evt,
  input logic             ev_ber,
  input logic [CH_W-1:0]  ev_ber_ch,
  input logic             sof0_ok
);

  a_r5_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(irq_level(stat0, stat1, ctl0, ctl5)));

  a_r7_sint_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && (|hit)) |=> stat0[S0_SINT]);

  a_r7_id_frozen_high: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> $stable(irq_id));

  a_r8_ber_field: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ber |=> (stat0[S0_BER] && stat0[S0_BCH +: 3] == 3'($past(ev_ber_ch))));

  a_r12_quick_disable: assert property (@(posedge clk) disable iff (!rst_n)
    qd_evt |=> stat0[S0_QD]);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sof0_ok |=> stat0[S0_SOF]);

  a_r10_bs1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat1[16] |=> stat1[16]);

endmodule

bind disp_irq_ctrl disp_irq_chk #(.NCH(NCH), .FID_W(FID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .stat0(stat0), .stat1(stat1),
  .ctl0(ctl0), .ctl5(ctl5), .irq_id(irq_id), .hit(hit), .qd_evt(qd_evt),
  .ev_ber(ev_ber), .ev_ber_ch(ev_ber_ch), .sof0_ok(ev_sof[0] & cmd_sof_en[0])
);

// File: tb/test_disp_irq_ctrl.sv
`timescale 1ns/1ps
module test_disp_irq_ctrl;

  localparam int NCH = 7;
  localparam int FW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] ev_sof = '0, ev_eof = '0, ev_bs = '0, ev_underrun = '0;
  logic [NCH-1:0] cmd_sof_en = '0, cmd_eof_en = '0;
  logic ev_ber = 1'b0, ev_out_underrun = 1'b0, ev_last_done = 1'b0;
  logic ev_read_status = 1'b0, ev_cmd_done = 1'b0;
  logic [2:0] ev_ber_ch = '0;
  logic [NCH*FW-1:0] frame_id_flat;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] fid(int c);
    return 32'h1000_0000 + 32'(c) * 32'h0001_0203 + 32'd7;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_fid
    assign frame_id_flat[c*FW +: FW] = fid(c);
  end

  disp_irq_ctrl #(.NCH(NCH), .FID_W(FW)) i_disp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_sof(ev_sof),
    .ev_eof(ev_eof), .ev_bs(ev_bs), .cmd_sof_en(cmd_sof_en),
    .cmd_eof_en(cmd_eof_en), .ev_ber(ev_ber), .ev_ber_ch(ev_ber_ch),
    .ev_underrun(ev_underrun), .ev_out_underrun(ev_out_underrun),
    .ev_last_done(ev_last_done), .ev_read_status(ev_read_status),
    .ev_cmd_done(ev_cmd_done), .frame_id_flat(frame_id_flat), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic clear_ev();
    ev_sof = '0; ev_eof = '0; ev_bs = '0; ev_underrun = '0; ev_ber = 1'b0;
    ev_out_underrun = 1'b0; ev_last_done = 1'b0; ev_read_status = 1'b0;
    ev_cmd_done = 1'b0; reg_wr = 1'b0;
  endtask

  // events driven since the last falling edge take effect at the next rising edge
  task automatic step();
    @(negedge clk);
    clear_ev();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic do_reset();
    clear_ev();
    cmd_sof_en = '1; cmd_eof_en = '1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R1 ctrl0", 3'd0, 32'h0);
    rd_chk("R1 ctrl5", 3'd1, 32'h0);
    rd_chk("R1 stat0", 3'd2, 32'h0);
    rd_chk("R1 stat1", 3'd3, 32'h0);
    rd_chk("R1 id", 3'd4, 32'h0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_ctrl_qd();
    do_reset();
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R13 ctrl0 keep", 3'd0, 32'h07FF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    rd_chk("R13 ctrl5 keep", 3'd1, 32'h3F3F_3F3F);
    rd_chk("R12 no qd on rise", 3'd2, 32'h0);
    wr(3'd0, 32'h0);
    rd_chk("R12 qd set", 3'd2, 32'h80);
    chk("R5 irq lags", irq_o, 0);
    @(negedge clk);
    chk("R5 irq from qd", irq_o, 1);
  endtask

  task automatic t_sof_sint();
    do_reset();
    ev_sof[0] = 1'b1;
    step();
    rd_chk("R2 sof0 bit", 3'd2, 32'h2);
    rd_chk("R6 id latched", 3'd4, fid(0));
    chk("R5 irq not yet", irq_o, 0);
    @(negedge clk);
    chk("R5 irq up", irq_o, 1);
    ev_eof[3] = 1'b1;
    step();
    rd_chk("R3 eof3 bit", 3'd3, 32'h400);
    rd_chk("R7 sint set", 3'd2, 32'h402);
    rd_chk("R7 id kept", 3'd4, fid(0));
  endtask

  task automatic t_gate();
    do_reset();
    cmd_sof_en = '0; cmd_eof_en = '0;
    ev_sof[2] = 1'b1; ev_eof[2] = 1'b1; ev_sof[0] = 1'b1; ev_eof[0] = 1'b1;
    step();
    rd_chk("R4 stat0 untouched", 3'd2, 32'h0);
    rd_chk("R4 stat1 untouched", 3'd3, 32'h0);
    rd_chk("R4 id untouched", 3'd4, 32'h0);
    @(negedge clk);
    chk("R4 irq low", irq_o, 0);
  endtask

  task automatic t_mask();
    do_reset();
    wr(3'd1, 32'h0002_0000);
    wr(3'd0, 32'h0000_0010);
    ev_bs[2] = 1'b1; ev_sof[0] = 1'b1;
    step();
    rd_chk("R3 bs2 bit", 3'd3, 32'h0002_0000);
    rd_chk("R2 masked sof0 recorded", 3'd2, 32'h2);
    rd_chk("R6 masked no id", 3'd4, 32'h0);
    @(negedge clk);
    chk("R5 masked irq low", irq_o, 0);
  endtask

  task automatic t_ber();
    do_reset();
    wr(3'd0, 32'h07FF_FFFF);
    wr(3'd1, 32'h3F3F_3F3F);
    ev_ber = 1'b1; ev_ber_ch = 3'd5;
    step();
    rd_chk("R8 ber and channel", 3'd2, 32'h5000_0004);
    rd_chk("R8 id from ber", 3'd4, fid(5));
    @(negedge clk);
    chk("R5 ber no irq", irq_o, 0);
    wr(3'd2, 32'h4);
    rd_chk("R9 ber clear field", 3'd2, 32'h0);
  endtask

  task automatic t_multi();
    do_reset();
    ev_sof[2] = 1'b1; ev_sof[4] = 1'b1;
    step();
    rd_chk("R3 sof2 sof4", 3'd3, 32'h0000_000A);
    rd_chk("R6 highest channel id", 3'd4, fid(4));
  endtask

  task automatic t_clr1();
    do_reset();
    ev_bs = 7'h7F; ev_sof = 7'h7E; ev_underrun = 7'b000_1000;
    step();
    rd_chk("R3 all ch events", 3'd3, 32'h043F_003F);
    rd_chk("R2 bs0 bit", 3'd2, 32'h200);
    wr(3'd3, 32'hFFFF_FFFF);
    rd_chk("R10 stat1 partial clear", 3'd3, 32'h0401_0000);
  endtask

  task automatic t_collide();
    do_reset();
    ev_sof[0] = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h2;
    step();
    rd_chk("R11 set beats clear", 3'd2, 32'h2);
  endtask

  task automatic t_rdst();
    do_reset();
    wr(3'd0, 32'h0080_0000);
    ev_sof[0] = 1'b1;
    step();
    @(negedge clk);
    chk("R5 irq before rdst", irq_o, 1);
    ev_read_status = 1'b1;
    step();
    rd_chk("R14 masked rdst no sint", 3'd2, 32'h802);
    wr(3'd0, 32'h0);
    ev_read_status = 1'b1;
    step();
    rd_chk("R14 unmasked rdst sint", 3'd2, 32'hC02);
  endtask

  task automatic t_misc();
    do_reset();
    ev_last_done = 1'b1; ev_out_underrun = 1'b1; ev_cmd_done = 1'b1;
    ev_underrun = 7'b000_0011;
    step();
    rd_chk("R2 global events", 3'd2, 32'h1071);
    @(negedge clk);
    chk("R5 irq global", irq_o, 1);
    wr(3'd2, 32'h0000_0FFF);
    rd_chk("R9 low bits cleared", 3'd2, 32'h1000);
    @(negedge clk);
    chk("R5 cmd keeps irq", irq_o, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ctrl_qd();
    t_sof_sint();
    t_gate();
    t_mask();
    t_ber();
    t_multi();
    t_clr1();
    t_collide();
    t_rdst();
    t_misc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule